// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Front End with Tag Lookup

This block is the front of a fine-grained multithreaded fetch unit. It holds one program counter per hardware thread. Every cycle a round-robin arbiter picks one thread from the set that the thread controller has enabled. The selected PC goes into a two-stage, set-associative tag lookup. In the first cycle, the tag and line-valid stores of every way are read at the PC's set index. In the second cycle, the stored tags are compared with the PC tag. The block then reports either a valid fetch or a cache miss, together with the PC and thread number it belongs to.

PC state is changed by four things: boot-time jobs, rollback requests from the back end, a miss, and normal scheduling. A miss rewinds the thread's PC by one instruction, so the missed fetch is issued again later. Line fills come from the miss handler outside this block. A fill writes a tag into the pseudo-LRU victim way and marks that way valid. When a fill lands in the same set that is being looked up in that cycle, the new tag and valid bit are forwarded straight into the lookup.

The instruction data array, the memory request path and the miss state machine live outside this block.

Top module: `fetch_front`

## Requirements
- R1: Each cycle the arbiter grants one thread among those whose `threadEn` bit is set, searching upward from the thread after the last grant and wrapping around. A thread whose enable bit is clear is never granted. With no thread enabled, no lookup starts, and `fetchValid` and `cacheMiss` stay low one cycle later.
- R2: At each clock edge a thread's PC is updated by the first of these rules that applies:
  - a job for that thread (`jobValid` with `jobTid` equal to the thread number) loads `jobPc`;
  - otherwise, `rollbackValid[t]` loads `rollbackPc[t*32 +: 32]`;
  - otherwise, if the thread has an unqualified miss (no way hits) in the second stage, the PC drops by 4;
  - otherwise, if the thread is granted in this cycle, the PC rises by 4.
- R3: The result for a grant appears on the outputs in the following cycle. `fetchPc` carries the PC that was granted and `fetchTid` carries the binary thread number.
- R4: The address is split into fields with the default parameters: bits [5:0] are the byte offset in the line, bits [10:6] are the set index, and bits [31:11] are the tag. A way hits when its stored tag equals the address tag and its line-valid bit is set.
- R5: `cacheMiss` is raised when a lookup is in the second stage, no way hits, and `rollbackValid` of that lookup's thread is low. `fetchValid` is raised under the same conditions except that at least one way hits. The two are never high together, and a rollback on the looked-up thread holds both low in that cycle.
- R6: A fill (`fillValid`, with `fillLine` holding address bits [31:6]) writes the line's tag into the victim way of its set and sets that way's valid bit. Later lookups of that line then hit.
- R7: If a fill in a cycle targets the same set as that cycle's lookup, the fill's tag and valid bit are forwarded into the lookup. A lookup of exactly the filled line therefore reports `fetchValid` one cycle later.
- R8: Each set keeps a binary-tree pseudo-LRU state. A hit and a fill both make their way most recently used, and a fill replaces the least recently used way. Starting from reset with no hits, successive fills to one set land in ways 0, 2, 1, 3 and then 0 again. So the fifth distinct line evicts the first line, and the second line stays resident.
- R9: After reset every PC is 0, every line is invalid, the next grant starts at thread 0, and `fetchValid` and `cacheMiss` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadEn | input | 4 | Per-thread eligibility from the thread controller |
| jobValid | input | 1 | Boot job strobe |
| jobTid | input | 2 | Thread that receives the job PC |
| jobPc | input | 32 | Start PC for the job |
| rollbackValid | input | 4 | Per-thread rollback request |
| rollbackPc | input | 128 | Restore PCs, thread t at bits [t*32 +: 32] |
| fillValid | input | 1 | A refilled line is being installed |
| fillLine | input | 26 | Line address (address bits 31:6) of the fill |
| fetchValid | output | 1 | Looked-up PC hit and may proceed |
| cacheMiss | output | 1 | Looked-up PC missed every way |
| fetchPc | output | 32 | PC of the result in the second stage |
| fetchTid | output | 2 | Thread of the result in the second stage |

## Verification
The bench targets several corner cases:
- The rewind rule when a thread misses while it is also granted again. A design that added 4 in that cycle instead of subtracting would skip an instruction.
- A job and a rollback arriving together for the same thread. A swapped priority would restart the thread at the rollback target.
- The same-cycle fill bypass. Without forwarding, the lookup sees a stale invalid line and reports a miss.
- Replacement order in a full set, traced through five fills. A wrong tree convention would evict a line other than the first.
- A rollback arriving while its thread is in the second stage. A design that ignored it would raise a miss or fetch for a flushed thread.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Strobes from the thread control half to the tag-lookup datapath
  typedef struct packed {
    logic lookupEn;   // a thread was granted this cycle; start a lookup
  } fetchStrobe_t;

endpackage

// File: rtl/fetch_tag_path.sv
module fetch_tag_path
  import fetch_pkg::*;
#(
  parameter int NUM_WAYS   = 4,
  parameter int NUM_SETS   = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int TID_W      = 2,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetchStrobe_t        strobe,
  input  logic [ADDR_W-1:0]   lookupPc,
  input  logic [TID_W-1:0]    lookupTid,
  input  logic                fillValid,
  input  logic [LINE_W-1:0]   fillLine,
  output logic                s1Valid,
  output logic [ADDR_W-1:0]   s1Pc,
  output logic [TID_W-1:0]    s1Tid,
  output logic                s1Miss
);

  localparam int TREE_W = NUM_WAYS - 1;

  // Tree nodes are numbered heap-style from 1; node n sits at bit n-1.
  // A node bit of 0 steers the victim search to the left child.
  function automatic logic [WAY_W-1:0] plruVictim(input logic [TREE_W-1:0] bits);
    int node;
    node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      node = 2 * node + (bits[node-1] ? 1 : 0);
    end
    return WAY_W'(node - NUM_WAYS);
  endfunction

  function automatic logic [TREE_W-1:0] plruTouch(input logic [TREE_W-1:0] bits,
                                                  input logic [WAY_W-1:0]  way);
    logic [TREE_W-1:0] res;
    int node;
    res  = bits;
    node = int'(way) + NUM_WAYS;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      res[(node >> 1) - 1] = ((node % 2) == 0);   // point away from the used child
      node = node >> 1;
    end
    return res;
  endfunction

  logic [TAG_W-1:0]   tagMem   [NUM_WAYS][NUM_SETS];
  logic [NUM_SETS-1:0] lineValid [NUM_WAYS];
  logic [TREE_W-1:0]  plruQ    [NUM_SETS];
  logic [TREE_W-1:0]  plruNext [NUM_SETS];

  logic [TAG_W-1:0]   tagRd    [NUM_WAYS];
  logic [NUM_WAYS-1:0] lvRd;
  logic [NUM_WAYS-1:0] hitWay;
  logic [WAY_W-1:0]   hitIdx;
  logic               anyHit;

  logic [IDX_W-1:0]   lookupIdx, fillIdx, s1Idx;
  logic [TAG_W-1:0]   fillTag, s1Tag;
  logic [WAY_W-1:0]   fillWay;
  logic               fillHere;

  assign lookupIdx = lookupPc[OFF_W +: IDX_W];
  assign fillIdx   = fillLine[IDX_W-1:0];
  assign fillTag   = fillLine[LINE_W-1:IDX_W];
  assign s1Idx     = s1Pc[OFF_W +: IDX_W];
  assign s1Tag     = s1Pc[ADDR_W-1 -: TAG_W];
  assign fillWay   = plruVictim(plruQ[fillIdx]);
  assign fillHere  = fillValid && (fillIdx == lookupIdx);

  // Stage 1: thread context register aligned with the tag read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Pc    <= '0;
      s1Tid   <= '0;
    end else begin
      s1Valid <= strobe.lookupEn;
      s1Pc    <= lookupPc;
      s1Tid   <= lookupTid;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    // Tag store write
    always_ff @(posedge clk) begin
      if (fillValid && fillWay == WAY_W'(w)) tagMem[w][fillIdx] <= fillTag;
    end

    always_ff @(posedge clk) begin
      if (!rstN) lineValid[w] <= '0;
      else if (fillValid && fillWay == WAY_W'(w)) lineValid[w][fillIdx] <= 1'b1;
    end

    // Registered read with same-cycle fill forwarding
    always_ff @(posedge clk) begin
      if (fillHere && fillWay == WAY_W'(w)) tagRd[w] <= fillTag;
      else                                  tagRd[w] <= tagMem[w][lookupIdx];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                 lvRd[w] <= 1'b0;
      else if (fillHere && fillWay == WAY_W'(w)) lvRd[w] <= 1'b1;
      else                                       lvRd[w] <= lineValid[w][lookupIdx] & strobe.lookupEn;
    end

    // Stage 2: per-way compare
    assign hitWay[w] = (tagRd[w] == s1Tag) && lvRd[w];
  end

  assign anyHit = |hitWay;
  assign s1Miss = s1Valid && !anyHit;

  always_comb begin
    hitIdx = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hitWay[w]) hitIdx = WAY_W'(w);
    end
  end

  // Replacement state: hit touch first, then fill touch
  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      plruNext[s] = plruQ[s];
      if (s1Valid && anyHit && s1Idx == IDX_W'(s)) plruNext[s] = plruTouch(plruNext[s], hitIdx);
      if (fillValid && fillIdx == IDX_W'(s))      plruNext[s] = plruTouch(plruNext[s], fillWay);
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rstN) plruQ[s] <= '0;
      else       plruQ[s] <= plruNext[s];
    end
  end

  // R7: a fill of exactly the looked-up line forces a hit one cycle later
  a_r7_fill_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookupEn && fillValid && fillLine == lookupPc[ADDR_W-1:OFF_W]) |=> (s1Valid && !s1Miss));

  // R6: the victim way of a fill is valid afterwards
  a_r6_fill_marks_valid: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> lineValid[$past(fillWay)][$past(fillIdx)]);

endmodule

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl
  import fetch_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS-1:0]        threadEn,
  input  logic                          jobValid,
  input  logic [TID_W-1:0]              jobTid,
  input  logic [ADDR_W-1:0]             jobPc,
  input  logic [NUM_THREADS-1:0]        rollbackValid,
  input  logic [NUM_THREADS*ADDR_W-1:0] rollbackPc,
  input  logic                          s1Valid,
  input  logic [TID_W-1:0]              s1Tid,
  input  logic                          s1Miss,
  output fetchStrobe_t                  strobe,
  output logic [ADDR_W-1:0]             lookupPc,
  output logic [TID_W-1:0]              selTid,
  output logic                          fetchValid,
  output logic                          cacheMiss
);

  logic [ADDR_W-1:0] pcQ [NUM_THREADS];
  logic [TID_W-1:0]  lastGrant;
  logic [TID_W-1:0]  cand;
  logic              found;
  logic              anyEn;
  logic              s1Rollback;

  assign anyEn = |threadEn;

  // Round-robin search starting after the last grant
  always_comb begin
    selTid = lastGrant;
    found  = 1'b0;
    cand   = '0;
    for (int i = 1; i <= NUM_THREADS; i++) begin
      cand = TID_W'((int'(lastGrant) + i) % NUM_THREADS);
      if (!found && threadEn[cand]) begin
        selTid = cand;
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      lastGrant <= TID_W'(NUM_THREADS - 1);
    else if (anyEn) lastGrant <= selTid;
  end

  assign strobe.lookupEn = anyEn;
  assign lookupPc        = pcQ[selTid];

  // Per-thread PC with fixed update priority
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pc
    always_ff @(posedge clk) begin
      if (!rstN)
        pcQ[t] <= '0;
      else if (jobValid && jobTid == TID_W'(t))
        pcQ[t] <= jobPc;
      else if (rollbackValid[t])
        pcQ[t] <= rollbackPc[t*ADDR_W +: ADDR_W];
      else if (s1Miss && s1Valid && s1Tid == TID_W'(t))
        pcQ[t] <= pcQ[t] - ADDR_W'(4);
      else if (anyEn && selTid == TID_W'(t))
        pcQ[t] <= pcQ[t] + ADDR_W'(4);
    end
  end

  assign s1Rollback = rollbackValid[s1Tid];
  assign fetchValid = s1Valid && !s1Rollback && !s1Miss;
  assign cacheMiss  = s1Valid && !s1Rollback &&  s1Miss;

  // R5: fetch and miss are exclusive
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchValid && cacheMiss));

  // R1: a lookup in stage 2 belongs to a thread enabled when it was granted
  a_r1_enabled_grant: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |-> ((($past(threadEn)) >> s1Tid) & NUM_THREADS'(1)) != '0);

  // R2: a job always overrides the other PC sources
  a_r2_job_loads: assert property (@(posedge clk) disable iff (!rstN)
    $past(jobValid) |-> pcQ[$past(jobTid)] == $past(jobPc));

  // R2: an unqualified miss without job or rollback rewinds by one instruction
  a_r2_miss_rewind: assert property (@(posedge clk) disable iff (!rstN)
    $past(s1Valid && s1Miss && !rollbackValid[s1Tid] && !(jobValid && jobTid == s1Tid))
      |-> pcQ[$past(s1Tid)] == $past(pcQ[s1Tid]) - ADDR_W'(4));

endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import fetch_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_WAYS    = 4,
  parameter int NUM_SETS    = 32,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int LINE_W     = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS-1:0]        threadEn,
  input  logic                          jobValid,
  input  logic [TID_W-1:0]              jobTid,
  input  logic [ADDR_W-1:0]             jobPc,
  input  logic [NUM_THREADS-1:0]        rollbackValid,
  input  logic [NUM_THREADS*ADDR_W-1:0] rollbackPc,
  input  logic                          fillValid,
  input  logic [LINE_W-1:0]             fillLine,
  output logic                          fetchValid,
  output logic                          cacheMiss,
  output logic [ADDR_W-1:0]             fetchPc,
  output logic [TID_W-1:0]              fetchTid
);

  fetchStrobe_t      strobe;
  logic [ADDR_W-1:0] lookupPc;
  logic [TID_W-1:0]  selTid;
  logic              s1Valid;
  logic              s1Miss;

  fetch_thread_ctrl #(
    .NUM_THREADS (NUM_THREADS),
    .ADDR_W      (ADDR_W)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .threadEn      (threadEn),
    .jobValid      (jobValid),
    .jobTid        (jobTid),
    .jobPc         (jobPc),
    .rollbackValid (rollbackValid),
    .rollbackPc    (rollbackPc),
    .s1Valid       (s1Valid),
    .s1Tid         (fetchTid),
    .s1Miss        (s1Miss),
    .strobe        (strobe),
    .lookupPc      (lookupPc),
    .selTid        (selTid),
    .fetchValid    (fetchValid),
    .cacheMiss     (cacheMiss)
  );

  fetch_tag_path #(
    .NUM_WAYS   (NUM_WAYS),
    .NUM_SETS   (NUM_SETS),
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .TID_W      (TID_W)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lookupPc  (lookupPc),
    .lookupTid (selTid),
    .fillValid (fillValid),
    .fillLine  (fillLine),
    .s1Valid   (s1Valid),
    .s1Pc      (fetchPc),
    .s1Tid     (fetchTid),
    .s1Miss    (s1Miss)
  );

endmodule

// File: tb/fetch_front_tb_top.sv
module fetch_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NT   = 4;
  localparam int NW   = 4;
  localparam int NS   = 32;
  localparam int AW   = 32;
  localparam int OFFW = 6;
  localparam int IDXW = 5;
  localparam int TAGW = AW - OFFW - IDXW;
  localparam int LW   = AW - OFFW;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NT-1:0]  threadEn = '0;
  logic           jobValid = 1'b0;
  logic [1:0]     jobTid = '0;
  logic [AW-1:0]  jobPc = '0;
  logic [NT-1:0]  rollbackValid = '0;
  logic [NT*AW-1:0] rollbackPc = '0;
  logic           fillValid = 1'b0;
  logic [LW-1:0]  fillLine = '0;
  logic           fetchValid, cacheMiss;
  logic [AW-1:0]  fetchPc;
  logic [1:0]     fetchTid;

  fetch_front dut_i (
    .clk(clk), .rstN(rstN), .threadEn(threadEn), .jobValid(jobValid), .jobTid(jobTid),
    .jobPc(jobPc), .rollbackValid(rollbackValid), .rollbackPc(rollbackPc),
    .fillValid(fillValid), .fillLine(fillLine), .fetchValid(fetchValid),
    .cacheMiss(cacheMiss), .fetchPc(fetchPc), .fetchTid(fetchTid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic          v;
    logic          m;
    logic          idChk;
    logic [AW-1:0] pc;
    logic [1:0]    tid;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  // Behavioural model state
  logic [AW-1:0]   mPc[NT];
  int              mLast;
  bit              mS1V;
  int              mS1Tid;
  logic [AW-1:0]   mS1Pc;
  logic [TAGW-1:0] mS1Tag[NW];
  bit              mS1Lv[NW];
  logic [TAGW-1:0] mTag[NW][NS];
  bit              mLv[NW][NS];
  logic [2:0]      mPlru[NS];

  // Direct (model-free) expectations
  bit    dirOn = 0;
  bit    dirValid, dirMiss;
  string dirTag;

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Four-way tree, written out: bit0 root, bit1 left pair, bit2 right pair
  function automatic int victim4(logic [2:0] b);
    if (!b[0]) return b[1] ? 1 : 0;
    return b[2] ? 3 : 2;
  endfunction

  function automatic logic [2:0] touch4(logic [2:0] b, int w);
    logic [2:0] r = b;
    if (w < 2) begin r[0] = 1'b1; r[1] = (w == 0); end
    else       begin r[0] = 1'b0; r[2] = (w == 2); end
    return r;
  endfunction

  task automatic cycle(string tag);
    expItem_t e;
    bit hitAny, miss, rb, any, found;
    int hw, sel, lIdx, fIdx, fw, s1Idx;
    logic [TAGW-1:0] fTag;
    logic [TAGW-1:0] nTag[NW];
    bit nLv[NW];
    logic [AW-1:0] pcSel;
    #1;
    if (dirOn) begin
      chk(dirTag, "direct fetchValid", AW'(fetchValid), AW'(dirValid));
      chk(dirTag, "direct cacheMiss", AW'(cacheMiss), AW'(dirMiss));
      dirOn = 0;
    end
    hitAny = 0; hw = 0;
    for (int w = 0; w < NW; w++)
      if (mS1Lv[w] && mS1Tag[w] == mS1Pc[AW-1:AW-TAGW]) begin hitAny = 1; hw = w; end
    miss = mS1V && !hitAny;
    rb   = mS1V && rollbackValid[mS1Tid];
    e.v = mS1V && !rb && !miss;
    e.m = mS1V && !rb && miss;
    e.idChk = mS1V && !rb;
    e.pc = mS1Pc;
    e.tid = 2'(mS1Tid);
    expQ.push_back(e);
    tagQ.push_back(tag);
    // next state
    s1Idx = int'(mS1Pc[OFFW +: IDXW]);
    fIdx  = int'(fillLine[IDXW-1:0]);
    fTag  = fillLine[LW-1:IDXW];
    fw    = victim4(mPlru[fIdx]);
    if (mS1V && hitAny) mPlru[s1Idx] = touch4(mPlru[s1Idx], hw);
    any = |threadEn; sel = mLast; found = 0;
    for (int i = 1; i <= NT; i++) begin
      int c = (mLast + i) % NT;
      if (!found && threadEn[c]) begin sel = c; found = 1; end
    end
    pcSel = mPc[sel];
    lIdx  = int'(pcSel[OFFW +: IDXW]);
    for (int w = 0; w < NW; w++) begin
      nTag[w] = mTag[w][lIdx];
      nLv[w]  = mLv[w][lIdx] && any;
      if (fillValid && fw == w && fIdx == lIdx) begin nTag[w] = fTag; nLv[w] = 1; end
    end
    if (fillValid) begin
      mTag[fw][fIdx] = fTag;
      mLv[fw][fIdx]  = 1;
      mPlru[fIdx]    = touch4(mPlru[fIdx], fw);
    end
    for (int t = 0; t < NT; t++) begin
      if (jobValid && int'(jobTid) == t)          mPc[t] = jobPc;
      else if (rollbackValid[t])                  mPc[t] = rollbackPc[t*AW +: AW];
      else if (mS1V && miss && mS1Tid == t)       mPc[t] = mPc[t] - 4;
      else if (any && sel == t)                   mPc[t] = mPc[t] + 4;
    end
    mS1V = any; mS1Tid = sel; mS1Pc = pcSel;
    for (int w = 0; w < NW; w++) begin mS1Tag[w] = nTag[w]; mS1Lv[w] = nLv[w]; end
    if (any) mLast = sel;
    @(negedge clk);
  endtask

  task automatic idleInputs();
    threadEn = '0; jobValid = 0; rollbackValid = '0; fillValid = 0;
  endtask

  // Monitor: pops expectations and compares against the outputs
  initial begin
    expItem_t e;
    string t;
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, "fetchValid (R5)", AW'(fetchValid), AW'(e.v));
        chk(t, "cacheMiss (R5)", AW'(cacheMiss), AW'(e.m));
        if (e.idChk) begin
          chk(t, "fetchPc (R3)", fetchPc, e.pc);
          chk(t, "fetchTid (R3)", AW'(fetchTid), AW'(e.tid));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nErrors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1234_5678;
    for (int t = 0; t < NT; t++) mPc[t] = '0;
    mLast = NT - 1; mS1V = 0; mS1Tid = 0; mS1Pc = '0;
    for (int w = 0; w < NW; w++) begin
      mS1Tag[w] = '0; mS1Lv[w] = 0;
      for (int s = 0; s < NS; s++) begin mTag[w][s] = '0; mLv[w][s] = 0; end
    end
    for (int s = 0; s < NS; s++) mPlru[s] = '0;

    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "fetchValid in reset", AW'(fetchValid), '0);
    chk("R9", "cacheMiss in reset", AW'(cacheMiss), '0);
    rstN = 1;

    // R9/R5/R2: thread 0 from PC 0, every lookup misses and rewinds
    threadEn = 4'b0001;
    repeat (6) cycle("R9 R5 R2 miss-rewind");

    // R2: boot jobs place each thread in its own set
    idleInputs();
    for (int t = 0; t < NT; t++) begin
      jobValid = 1; jobTid = 2'(t); jobPc = AW'(t * 32'h40);
      cycle("R2 job");
    end
    idleInputs();
    // R6: install those lines
    for (int t = 0; t < NT; t++) begin
      fillValid = 1; fillLine = LW'(t);
      cycle("R6 fill");
    end
    idleInputs();
    // R1/R3/R4: all threads enabled, hits
    threadEn = 4'b1111;
    repeat (24) cycle("R1 R3 R4 hit");
    threadEn = 4'b0101;
    repeat (8) cycle("R1 subset");
    // R2/R5: rollback on thread 1, job and rollback together on thread 3
    threadEn = 4'b1111;
    rollbackValid = 4'b1010;
    rollbackPc[1*AW +: AW] = 32'h0000_0404;
    rollbackPc[3*AW +: AW] = 32'h0000_0800;
    jobValid = 1; jobTid = 2'd3; jobPc = 32'h0000_00C8;
    cycle("R2 R5 rollback");
    rollbackValid = '0; jobValid = 0;
    repeat (8) cycle("R2 R5 after-rollback");

    // R7: fill the looked-up line in the same cycle
    idleInputs();
    jobValid = 1; jobTid = 2'd0; jobPc = 32'h0000_2000;
    cycle("R7 setup");
    idleInputs();
    threadEn = 4'b0001; fillValid = 1; fillLine = LW'(32'h0000_2000 >> OFFW);
    cycle("R7 bypass");
    idleInputs();
    dirOn = 1; dirValid = 1; dirMiss = 0; dirTag = "R7";
    cycle("R7 result");

    // R8: five fills to set 5 evict the first line, the second stays
    for (int k = 1; k <= 5; k++) begin
      fillValid = 1; fillLine = LW'((k << IDXW) | 5);
      cycle("R8 fills");
    end
    idleInputs();
    jobValid = 1; jobTid = 2'd0; jobPc = AW'((1 << 11) | (5 << 6));
    cycle("R8 job1");
    idleInputs(); threadEn = 4'b0001;
    cycle("R8 look1");
    idleInputs();
    dirOn = 1; dirValid = 0; dirMiss = 1; dirTag = "R8 evicted";
    cycle("R8 res1");
    jobValid = 1; jobTid = 2'd0; jobPc = AW'((2 << 11) | (5 << 6));
    cycle("R8 job2");
    idleInputs(); threadEn = 4'b0001;
    cycle("R8 look2");
    idleInputs();
    dirOn = 1; dirValid = 1; dirMiss = 0; dirTag = "R8 resident";
    cycle("R8 res2");

    // Mixed traffic
    for (int n = 0; n < 300; n++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      threadEn = lf[3:0];
      jobValid = (lf[6:4] == 3'd0);
      jobTid   = lf[9:8];
      jobPc    = AW'({lf[17:16], 5'(lf[22:20] & 3'h7), lf[27:24], 2'b00});
      rollbackValid = (lf[12:10] == 3'd0) ? (4'b0001 << lf[14:13]) : 4'b0000;
      for (int t = 0; t < NT; t++)
        rollbackPc[t*AW +: AW] = AW'({lf[19:18], 5'(lf[30:28]), 4'(t), 2'b00});
      fillValid = lf[15];
      fillLine  = LW'({lf[23:22], 5'(lf[26:25] + 2'(t_zero()))});
      cycle("R1 R2 R4 R5 R6 R7 R8 mixed");
    end
    idleInputs();
    repeat (2) cycle("R1 idle");
    #3;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  function automatic int t_zero();
    return 0;
  endfunction

endmodule